// File: doc/BRIEF.md
# Audio Serial Port Clock Generator

This block produces the bit clock and the frame (left/right) clock of a stereo audio serial port. Both are derived from the module clock `clk_i`. A 16-bit control word, `ctrl_i`, sets the following:

- whether the port drives its clocks or follows clocks from outside;
- the polarity of each clock;
- the bit-clock divisor and the frame length;
- the sample word size;
- the alignment of the frame clock against the data.

As clock master, the block drives both clocks with output enables high. It also reports which bit slot holds a sample MSB (`msb_o`) and which channel the current slot belongs to (`chan_o`). As clock slave, the enables drop and the external clocks pass through with the selected polarity applied.

The control word is captured into an active copy. In master mode the copy is reloaded only when a frame ends, so a reconfiguration never cuts a clock phase short. In slave mode the copy follows `ctrl_i` on every cycle.

Top module: `aclk_gen`

## Requirements
- R1: While reset is held, and after its release with `ctrl_i[15]`=1, both output enables, `msb_o` and `chan_o` are low.
- R2: As master (`ctrl_i[15]`=0), the divide code in `ctrl_i[12:9]` sets the module clocks per bit-clock period. Codes 0..13 select 1,2,4,6,8,12,16,24,32,48,64,96,128,192. An even divisor N gives a bit clock that is high for N/2 module clocks. Divisor 1 outputs the inverted module clock: low while `clk_i` is high.
- R3: The frame code f in `ctrl_i[8:6]` sets 16·2^f bit clocks per frame. The frame clock therefore repeats every divisor·16·2^f module clocks and changes only at bit-clock period boundaries.
- R4: Format code 0 in `ctrl_i[3:2]` (I2S): the frame clock is low for the left half. The left MSB slot starts one bit clock after the frame clock falls, and the bit clock is low at that fall.
- R5: Format code 1 (left-justified): the frame clock is high for the left half, and the left MSB slot starts together with its rise.
- R6: Format code 2 (right-justified): the MSB slot starts W bit clocks before the end of each half-frame. W comes from `ctrl_i[5:4]`: 0→8, 1→16, 2→20, 3→24, and is limited to half the frame.
- R7: Format code 3 (DSP): the frame clock is a one-bit-clock high pulse at frame start. The left MSB follows it directly, and the right MSB comes W bit clocks after the left MSB.
- R8: `ctrl_i[14]` inverts the bit clock and `ctrl_i[13]` inverts the frame clock, each independently of the other.
- R9: With `ctrl_i[15]`=1, both output enables are low and `msb_o`/`chan_o` are low. `bclk_o` equals `ext_bclk_i` XOR `ctrl_i[14]`, and `lrck_o` equals `ext_lrck_i` XOR `ctrl_i[13]`.
- R10: As master, a new control word takes effect only at the next frame boundary. The frame in progress completes with the old timing.
- R11: A divide code above 13 acts as 13, and a frame code above 4 acts as 4.
- R12: `chan_o` is 0 during the left MSB slot and 1 during the right MSB slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 16 | Control word (role, polarity, divider, frame, word size, format) |
| ext_bclk_i | input | 1 | Bit clock from outside, used in slave role |
| ext_lrck_i | input | 1 | Frame clock from outside, used in slave role |
| bclk_o | output | 1 | Bit clock, polarity applied |
| bclk_oe_o | output | 1 | Bit-clock pad drive enable |
| lrck_o | output | 1 | Frame clock, polarity applied |
| lrck_oe_o | output | 1 | Frame-clock pad drive enable |
| msb_o | output | 1 | High for the bit-clock period that carries a sample MSB |
| chan_o | output | 1 | Channel of the current slot (0 left, 1 right) |

## Verification
The assertions assume that `ctrl_i` is stable around each rising edge of `clk_i`. They also assume that the external clocks matter only in slave role, because they never reach the internal counters. The bench changes `ctrl_i` and the external clocks only on falling edges. After each change of role or configuration, it waits longer than the previous frame before it measures anything. It measures timing as clock counts between frame-clock transitions, so every figure is relative to an observed boundary and not to absolute time.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } fmt_e;

  typedef struct packed {
    logic       slave;
    logic       inv_b;
    logic       inv_l;
    logic [3:0] dcode;
    logic [2:0] fcode;
    logic [1:0] wsz;
    fmt_e       fmt;
    logic [1:0] spare;
  } ctl_t;

  // module clocks per bit-clock period for a divide code
  function automatic int unsigned div_of(input int unsigned code);
    if (code == 0)           return 1;
    else if (code == 1)      return 2;
    else if (code[0] == 1'b0) return 32'd1 << (code / 2 + 1);
    else                     return 32'd3 << ((code - 1) / 2);
  endfunction

  function automatic int unsigned word_bits(input logic [1:0] w);
    case (w)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/aclk_bclk_div.sv
module aclk_bclk_div #(
  parameter int HALF_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              bypass_i,
  input  logic [HALF_W-1:0] half_m1_i,
  output logic              bclk_o,
  output logic              per_end_o
);

  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              tgl_q, tgl_d;
  logic              at_half;

  always_comb begin
    cnt_d     = cnt_q;
    tgl_d     = tgl_q;
    per_end_o = 1'b0;
    at_half   = (cnt_q == half_m1_i);
    if (!run_i) begin
      cnt_d = '0;
      tgl_d = 1'b0;
    end else if (bypass_i) begin
      cnt_d     = '0;
      tgl_d     = 1'b0;
      per_end_o = 1'b1;
    end else if (at_half) begin
      cnt_d     = '0;
      tgl_d     = ~tgl_q;
      per_end_o = tgl_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tgl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tgl_q <= tgl_d;
    end
  end

  assign bclk_o = tgl_q;

endmodule

// File: rtl/aclk_frame_ctr.sv
module aclk_frame_ctr #(
  parameter int POS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [POS_W-1:0] last_i,
  output logic [POS_W-1:0] pos_o,
  output logic             frame_end_o
);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             wrap;

  always_comb begin
    wrap        = (pos_q == last_i);
    frame_end_o = run_i & step_i & wrap;
    pos_d       = pos_q;
    if (!run_i)      pos_d = '0;
    else if (step_i) pos_d = wrap ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else         pos_q <= pos_d;
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/aclk_slot_dec.sv
module aclk_slot_dec
  import aclk_pkg::*;
#(
  parameter int POS_W = 8,
  parameter int FC_W  = 3
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic [FC_W-1:0]  fcode_i,
  input  logic [1:0]       wsz_i,
  input  fmt_e             fmt_i,
  output logic             lrck_o,
  output logic             msb_o,
  output logic             chan_o
);

  always_comb begin
    int unsigned p, h, sw;
    p  = 32'(pos_i);
    h  = 32'd8 << fcode_i;
    sw = word_bits(wsz_i);
    if (sw > h) sw = h;
    case (fmt_i)
      FMT_I2S: begin
        lrck_o = (p >= h);
        msb_o  = (p == 1) || (p == h + 1);
        chan_o = (p == 0) || (p > h);
      end
      FMT_LJ: begin
        lrck_o = (p < h);
        msb_o  = (p == 0) || (p == h);
        chan_o = (p >= h);
      end
      FMT_RJ: begin
        lrck_o = (p < h);
        msb_o  = (p == h - sw) || (p == 2 * h - sw);
        chan_o = (p >= h);
      end
      default: begin
        lrck_o = (p == 0);
        msb_o  = (p == 1) || (p == sw + 1);
        chan_o = (p > sw);
      end
    endcase
  end

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
  import aclk_pkg::*;
#(
  parameter int DCODE_MAX = 13,
  parameter int FCODE_MAX = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] ctrl_i,
  input  logic        ext_bclk_i,
  input  logic        ext_lrck_i,
  output logic        bclk_o,
  output logic        bclk_oe_o,
  output logic        lrck_o,
  output logic        lrck_oe_o,
  output logic        msb_o,
  output logic        chan_o
);

  localparam int DIV_MAX = div_of(DCODE_MAX);
  localparam int HALF_W  = $clog2(DIV_MAX / 2 + 1);
  localparam int POS_W   = FCODE_MAX + 4;
  localparam int FC_W    = 3;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  ctl_t             act_q, act_d;
  logic             run, bypass, per_end, frame_end, bclk_div_q;
  logic [3:0]       dc;
  logic [FC_W-1:0]  fc;
  logic [HALF_W-1:0] half_m1;
  logic [POS_W-1:0] pos_q, last_pos;
  logic             lrck_raw, msb_raw, chan_raw;

  // active copy: follows the input in slave role, else reloads at frame end
  always_comb begin
    act_d = act_q;
    if (act_q.slave || frame_end) act_d = ctl_t'(ctrl_i);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) act_q <= ctl_t'(16'h8000);
    else        act_q <= act_d;
  end

  always_comb begin
    int unsigned div;
    dc       = (act_q.dcode > 4'(DCODE_MAX)) ? 4'(DCODE_MAX) : act_q.dcode;
    fc       = (act_q.fcode > FC_W'(FCODE_MAX)) ? FC_W'(FCODE_MAX) : act_q.fcode;
    div      = div_of(32'(dc));
    bypass   = (dc == 4'd0);
    half_m1  = bypass ? '0 : HALF_W'(div / 2 - 1);
    last_pos = POS_W'((32'd16 << fc) - 1);
    run      = ~act_q.slave;
  end

  aclk_bclk_div #(.HALF_W(HALF_W)) div_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .run_i     (run),
    .bypass_i  (bypass),
    .half_m1_i (half_m1),
    .bclk_o    (bclk_div_q),
    .per_end_o (per_end)
  );

  aclk_frame_ctr #(.POS_W(POS_W)) frm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .run_i       (run),
    .step_i      (per_end),
    .last_i      (last_pos),
    .pos_o       (pos_q),
    .frame_end_o (frame_end)
  );

  aclk_slot_dec #(.POS_W(POS_W), .FC_W(FC_W)) dec_i (
    .pos_i   (pos_q),
    .fcode_i (fc),
    .wsz_i   (act_q.wsz),
    .fmt_i   (act_q.fmt),
    .lrck_o  (lrck_raw),
    .msb_o   (msb_raw),
    .chan_o  (chan_raw)
  );

  // pad side: index 0 bit clock, index 1 frame clock
  logic [1:0] int_clk, ext_clk, inv, pad;
  assign int_clk = {lrck_raw, (bypass ? ~clk_i : bclk_div_q)};
  assign ext_clk = {ext_lrck_i, ext_bclk_i};
  assign inv     = {act_q.inv_l, act_q.inv_b};

  for (genvar g = 0; g < 2; g++) begin : g_pad
    assign pad[g] = (run ? int_clk[g] : ext_clk[g]) ^ inv[g];
  end

  assign bclk_o    = pad[0];
  assign lrck_o    = pad[1];
  assign bclk_oe_o = run;
  assign lrck_oe_o = run;
  assign msb_o     = run & msb_raw;
  assign chan_o    = run & chan_raw;

endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk #(
  parameter int POS_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [15:0]      ctrl_i,
  input logic             bclk_oe_o,
  input logic             lrck_oe_o,
  input logic             lrck_o,
  input logic             msb_o,
  input logic             chan_o,
  input logic             per_end,
  input logic             frame_end,
  input logic [15:0]      act_q,
  input logic [POS_W-1:0] pos_q,
  input logic [POS_W-1:0] last_pos
);

  // R9
  master_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_oe_o) |-> !$past(ctrl_i[15]));

  // R9
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lrck_oe_o |-> (!msb_o && !chan_o));

  // R3
  lrck_on_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lrck_oe_o && $past(lrck_oe_o) && !$stable(lrck_o)) |-> $past(per_end));

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclk_oe_o && $past(bclk_oe_o) && !$stable(act_q)) |-> $past(frame_end));

  // R3
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_oe_o |-> (pos_q <= last_pos));

endmodule

bind aclk_gen aclk_gen_chk #(.POS_W(POS_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_i    (ctrl_i),
  .bclk_oe_o (bclk_oe_o),
  .lrck_oe_o (lrck_oe_o),
  .lrck_o    (lrck_o),
  .msb_o     (msb_o),
  .chan_o    (chan_o),
  .per_end   (per_end),
  .frame_end (frame_end),
  .act_q     (act_q),
  .pos_q     (pos_q),
  .last_pos  (last_pos)
);

// File: tb/aclk_gen_tb_top.sv
module aclk_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ctrl;
  logic        ext_bclk, ext_lrck;
  logic        bclk, bclk_oe, lrck, lrck_oe, msb, chan;

  int tests = 0;
  int fails = 0;
  int cur_len = 0;

  always #4 clk = ~clk;

  aclk_gen dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ctrl_i     (ctrl),
    .ext_bclk_i (ext_bclk),
    .ext_lrck_i (ext_lrck),
    .bclk_o     (bclk),
    .bclk_oe_o  (bclk_oe),
    .lrck_o     (lrck),
    .lrck_oe_o  (lrck_oe),
    .msb_o      (msb),
    .chan_o     (chan)
  );

  function automatic logic [15:0] mk(input logic sl, input logic ib, input logic il,
                                     input logic [3:0] dc, input logic [2:0] fc,
                                     input logic [1:0] ws, input logic [1:0] fm);
    return {sl, ib, il, dc, fc, ws, fm, 2'b00};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [15:0] v, input int len);
    @(negedge clk);
    ctrl = v;
    repeat (cur_len + 8) @(negedge clk);
    cur_len = len;
  endtask

  task automatic sync_lrck(input logic v);
    logic prev;
    @(negedge clk);
    prev = lrck;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      if (prev !== v && lrck === v) break;
      prev = lrck;
    end
  endtask

  task automatic next_period(input logic v, output int n);
    logic prev;
    prev = lrck;
    n = 0;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      if (prev !== v && lrck === v) break;
      prev = lrck;
    end
  endtask

  task automatic to_msb(output int n);
    n = 0;
    while (msb !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic msb_next(output int n);
    n = 0;
    while (msb === 1'b1 && n < 20000) begin @(negedge clk); n++; end
    while (msb !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic bclk_high(output int n);
    logic prev;
    @(negedge clk);
    prev = bclk;
    for (int g = 0; g < 20000; g++) begin
      @(negedge clk);
      if (prev === 1'b0 && bclk === 1'b1) break;
      prev = bclk;
    end
    n = 1;
    while (n < 20000) begin
      @(negedge clk);
      if (bclk === 1'b1) n++;
      else break;
    end
  endtask

  task automatic t_reset;
    chk("R1 oe in reset", int'(bclk_oe) + int'(lrck_oe), 0);
    chk("R1 msb/chan in reset", int'(msb) + int'(chan), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe after release", int'(bclk_oe), 0);
    chk("R1 msb after release", int'(msb), 0);
  endtask

  task automatic t_i2s;
    int n;
    set_cfg(mk(0, 0, 0, 4'd2, 3'd1, 2'd1, 2'd0), 128);
    sync_lrck(1'b0);
    chk("R4 bclk low at lrck fall", int'(bclk), 0);
    to_msb(n);
    chk("R4 i2s msb delay", n, 4);
    sync_lrck(1'b0);
    next_period(1'b0, n);
    chk("R3 frame period div4 f32", n, 128);
  endtask

  task automatic t_lj;
    int n;
    set_cfg(mk(0, 0, 0, 4'd1, 3'd0, 2'd1, 2'd1), 32);
    sync_lrck(1'b1);
    chk("R5 lj msb at lrck rise", int'(msb), 1);
    chk("R12 left chan", int'(chan), 0);
    msb_next(n);
    chk("R5 lj right msb offset", n, 16);
    chk("R12 right chan", int'(chan), 1);
  endtask

  task automatic t_rj;
    int n;
    set_cfg(mk(0, 0, 0, 4'd1, 3'd2, 2'd1, 2'd2), 128);
    sync_lrck(1'b1);
    to_msb(n);
    chk("R6 rj msb offset", n, 32);
  endtask

  task automatic t_dsp;
    int n;
    set_cfg(mk(0, 0, 0, 4'd2, 3'd1, 2'd1, 2'd3), 128);
    sync_lrck(1'b1);
    n = 0;
    while (lrck === 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk("R7 dsp pulse width", n, 4);
    chk("R7 dsp left msb after pulse", int'(msb), 1);
    msb_next(n);
    chk("R7 dsp right msb offset", n, 64);
  endtask

  task automatic t_inv;
    int n;
    set_cfg(mk(0, 1, 1, 4'd2, 3'd1, 2'd1, 2'd0), 128);
    sync_lrck(1'b1);
    chk("R8 bclk inverted at frame start", int'(bclk), 1);
    to_msb(n);
    chk("R8 inverted lrck msb delay", n, 4);
  endtask

  task automatic t_div;
    int n;
    set_cfg(mk(0, 0, 0, 4'd5, 3'd0, 2'd1, 2'd1), 192);
    bclk_high(n);
    chk("R2 div12 high time", n, 6);
    set_cfg(mk(0, 0, 0, 4'd9, 3'd0, 2'd1, 2'd1), 768);
    bclk_high(n);
    chk("R2 div48 high time", n, 24);
  endtask

  task automatic t_bypass;
    int n;
    set_cfg(mk(0, 0, 0, 4'd0, 3'd6, 2'd1, 2'd1), 256);
    sync_lrck(1'b1);
    next_period(1'b1, n);
    chk("R11 frame code 6 acts as 4", n, 256);
    @(posedge clk); #2;
    chk("R2 bypass bclk while clk high", int'(bclk), 0);
    @(negedge clk); #2;
    chk("R2 bypass bclk while clk low", int'(bclk), 1);
  endtask

  task automatic t_clamp;
    int n;
    set_cfg(mk(0, 0, 0, 4'd15, 3'd0, 2'd1, 2'd1), 3072);
    bclk_high(n);
    chk("R11 div code 15 acts as 13", n, 96);
  endtask

  task automatic t_boundary;
    int n;
    set_cfg(mk(0, 0, 0, 4'd2, 3'd0, 2'd1, 2'd1), 64);
    sync_lrck(1'b1);
    repeat (10) @(negedge clk);
    ctrl = mk(0, 0, 0, 4'd4, 3'd0, 2'd1, 2'd1);
    next_period(1'b1, n);
    chk("R10 old frame completes", n, 54);
    next_period(1'b1, n);
    chk("R10 new frame timing", n, 128);
    cur_len = 128;
  endtask

  task automatic t_slave;
    set_cfg(mk(1, 1, 0, 4'd2, 3'd0, 2'd1, 2'd1), 0);
    chk("R9 oe low in slave", int'(bclk_oe) + int'(lrck_oe), 0);
    ext_bclk = 1'b1;
    ext_lrck = 1'b1;
    #1;
    chk("R9 bclk passthrough inverted", int'(bclk), 0);
    chk("R9 lrck passthrough", int'(lrck), 1);
    chk("R9 msb low in slave", int'(msb), 0);
    ext_bclk = 1'b0;
    #1;
    chk("R9 bclk follows ext", int'(bclk), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    ctrl     = 16'h8000;
    ext_bclk = 1'b0;
    ext_lrck = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_i2s();
    t_lj();
    t_rj();
    t_dsp();
    t_inv();
    t_div();
    t_bypass();
    t_clamp();
    t_boundary();
    t_slave();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule